// File: doc/BRIEF.md
# Far Transfer Gate Privilege Checker

This block rules on a far JMP or far CALL before the control-transfer datapath acts on it. Each request carries the current privilege level, the far pointer (selector and offset, where the two low selector bits are the requested level), the 64-bit descriptor that the selector names, and, when that descriptor is a call gate, the 64-bit descriptor of the code segment the gate leads to. One cycle later the block answers with allow or fault (with a fault class), plus the code selector and entry offset to load, the new current privilege level, a stack-switch request and the count of parameter dwords to copy.

Three rule sets apply. A direct transfer to a non-conforming code segment must stay at the same level. A direct transfer to a conforming segment may reach inward while the level stays the same. A call gate admits a transfer only when target level ≤ max(current, requested) ≤ gate level. Only a CALL through a gate may raise privilege, and in that case a stack switch is requested. Descriptor fetch, the stack-copy datapath, task switching and returns belong to other blocks.

Top module: `far_xfer_gate_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_fault`, `rsp_cause`, `rsp_cpl`, `rsp_stack_sw` and `rsp_pcount` go to 0 on that edge, and a request presented in that cycle produces no response.
- R2: A request sampled with `req_valid` high at an edge gives `rsp_valid` high after exactly that edge. A cycle without a request gives `rsp_valid` low after the next edge.
- R3: A descriptor is a code segment when bit 44 (S) is 1 and bit 43 is 1, and it is non-conforming when bit 42 is 0. The DPL is in bits 46:45. A direct transfer to a non-conforming code segment is allowed only when its DPL equals the current level, whatever the requested level. On success the selector is the pointer's bits 15:2 with bits 1:0 set to the current level, the offset is the pointer's offset, and the level stays the same.
- R4: A direct transfer to a conforming code segment (bit 42 = 1) is allowed when its DPL ≤ the current level. The level stays the same and there is no stack switch. A conforming segment with a larger DPL faults with cause 2.
- R5: A descriptor that is neither a code segment nor a call gate (data with S = 1 and bit 43 = 0, or any other system type) faults with cause 1.
- R6: A call gate has S = 0 and bits 42:40 = 100. Bit 43 selects a 32-bit gate. The target selector is in bits 31:16, the offset low half in bits 15:0, the offset high half in bits 63:48 (used only by a 32-bit gate, otherwise zero), and the dword count in bits 36:32.
- R7: A gate transfer faults with cause 1 when the target is not a code segment. It faults with cause 2 unless target DPL ≤ max(current, requested) ≤ gate DPL, and it also faults with cause 2 when the target DPL is larger than the current level.
- R8: A CALL through a gate to a non-conforming target with DPL below the current level is allowed. The new level is the target DPL, `rsp_stack_sw` is 1 and `rsp_pcount` is the gate's count (0 to 31). The selector takes bits 15:2 from the gate's selector and bits 1:0 from the new level, so the gate selector's own requested-level bits are ignored.
- R9: A JMP that would raise privilege through a gate faults with cause 3.
- R10: A gate transfer to a conforming target, or to a target at the current level, keeps the level, with `rsp_stack_sw` = 0 and `rsp_pcount` = 0.
- R11: A faulting response has `rsp_fault` = 1, `rsp_sel` = 0, `rsp_off` = 0, `rsp_cpl` = the current level, `rsp_stack_sw` = 0 and `rsp_pcount` = 0. The cause codes are 0 none, 1 bad type, 2 privilege, 3 JMP raising privilege. An allowed response has cause 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_call | input | 1 | 1 = far CALL, 0 = far JMP |
| cur_pl | input | 2 | Current privilege level |
| ptr_sel | input | 16 | Far pointer selector, bits 1:0 = requested level |
| ptr_off | input | 32 | Far pointer offset |
| ref_desc | input | 64 | Descriptor named by the pointer selector |
| tgt_desc | input | 64 | Target code descriptor named by a gate |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Transfer refused |
| rsp_cause | output | 2 | Fault class (0 none, 1 type, 2 privilege, 3 JMP raise) |
| rsp_sel | output | 16 | Code selector to load |
| rsp_off | output | 32 | Entry offset |
| rsp_cpl | output | 2 | New current privilege level |
| rsp_stack_sw | output | 1 | Stack switch with parameter copy needed |
| rsp_pcount | output | 5 | Parameter dwords to copy |

## Verification
The bench targets cases where a single wrong comparison lets a transfer through. A gate whose DPL is below the current level while the requested level is low would pass a design that checks only the requested level. A target less privileged than the current level but within the requested level would pass a design that trusts the three-way window alone. A JMP to an inner non-conforming target would raise privilege in a design that ignores the CALL/JMP distinction. A 16-bit gate with a populated high offset, and a gate selector whose requested-level bits are 3, catch a design that neither zero-extends the offset nor replaces those bits with the new level.

// File: rtl/fxfer_pkg.sv
// Shared widths, descriptor field positions, fault classes and decoded form.
// Assumes the fixed 64-bit segment/gate descriptor layout.
package fxfer_pkg;
    localparam int PL_W    = 2;
    localparam int SEL_W   = 16;
    localparam int IDX_W   = SEL_W - PL_W;
    localparam int OFF_W   = 32;
    localparam int HALF_W  = OFF_W / 2;
    localparam int CNT_W   = 5;
    localparam int DESC_W  = 64;

    // Access-byte and field positions within a descriptor
    localparam int TYPE_LO  = 40;
    localparam int S_BIT    = 44;
    localparam int DPL_LO   = 45;
    localparam int CNT_LO   = 32;
    localparam int GSEL_LO  = 16;
    localparam int OFFH_LO  = 48;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_TYPE      = 2'd1,
        CAUSE_PRIV      = 2'd2,
        CAUSE_JMP_RAISE = 2'd3
    } cause_t;

    typedef struct packed {
        logic              is_code;
        logic              conforming;
        logic              is_gate;
        logic [PL_W-1:0]   dpl;
        logic [IDX_W-1:0]  gidx;
        logic [OFF_W-1:0]  goff;
        logic [CNT_W-1:0]  gcnt;
    } desc_info_t;
endpackage

// File: rtl/fxfer_desc_decode.sv
// Splits a raw descriptor into the fields the privilege rules need.
// Assumes the caller only trusts gate fields when is_gate is set.
module fxfer_desc_decode
    import fxfer_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output desc_info_t        info
);
    logic [3:0] dtype;
    logic       sys_n;
    logic       unused_desc_bits;

    assign dtype = desc[TYPE_LO +: 4];
    assign sys_n = desc[S_BIT];
    assign unused_desc_bits = ^{desc[S_BIT+3], desc[CNT_LO+CNT_W +: 3], desc[GSEL_LO +: PL_W]};

    // Field extraction and class decode
    always_comb begin
        info.is_code    = sys_n && dtype[3];
        info.conforming = dtype[2];
        info.is_gate    = !sys_n && (dtype[2:0] == 3'b100);
        info.dpl        = desc[DPL_LO +: PL_W];
        info.gidx       = desc[GSEL_LO+PL_W +: IDX_W];
        info.gcnt       = desc[CNT_LO +: CNT_W];
        info.goff       = {dtype[3] ? desc[OFFH_LO +: HALF_W] : {HALF_W{1'b0}}, desc[0 +: HALF_W]};
    end
endmodule

// File: rtl/fxfer_rules.sv
// Applies the direct, conforming and gate privilege rules to decoded
// descriptors and forms the transfer result. Purely combinational;
// clk/rst_n only time the embedded assertions.
module fxfer_rules
    import fxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_call,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [OFF_W-1:0]  ptr_off,
    input  desc_info_t        src,
    input  desc_info_t        tgt,
    output logic              fault,
    output cause_t            cause,
    output logic [SEL_W-1:0]  sel,
    output logic [OFF_W-1:0]  off,
    output logic [PL_W-1:0]   new_pl,
    output logic              stack_sw,
    output logic [CNT_W-1:0]  pcount
);
    logic [PL_W-1:0] rpl;
    logic [PL_W-1:0] eff;
    logic            unused_tgt_bits;

    assign rpl = ptr_sel[PL_W-1:0];
    assign eff = (cur_pl > rpl) ? cur_pl : rpl;
    assign unused_tgt_bits = ^{tgt.is_gate, tgt.gidx, tgt.goff, tgt.gcnt};

    // Decision tree: type first, then privilege window, then raise rules
    always_comb begin
        fault    = 1'b1;
        cause    = CAUSE_TYPE;
        sel      = '0;
        off      = '0;
        new_pl   = cur_pl;
        stack_sw = 1'b0;
        pcount   = '0;
        if (src.is_code) begin
            if (src.conforming ? (src.dpl <= cur_pl) : (src.dpl == cur_pl)) begin
                fault = 1'b0;
                cause = CAUSE_NONE;
                sel   = {ptr_sel[SEL_W-1:PL_W], cur_pl};
                off   = ptr_off;
            end else begin
                cause = CAUSE_PRIV;
            end
        end else if (src.is_gate) begin
            if (!tgt.is_code) begin
                cause = CAUSE_TYPE;
            end else if (!((tgt.dpl <= eff) && (eff <= src.dpl)) || (tgt.dpl > cur_pl)) begin
                cause = CAUSE_PRIV;
            end else if (!tgt.conforming && (tgt.dpl < cur_pl) && !is_call) begin
                cause = CAUSE_JMP_RAISE;
            end else begin
                fault = 1'b0;
                cause = CAUSE_NONE;
                if (!tgt.conforming && (tgt.dpl < cur_pl)) begin
                    new_pl   = tgt.dpl;
                    stack_sw = 1'b1;
                    pcount   = src.gcnt;
                end
                sel = {src.gidx, new_pl};
                off = src.goff;
            end
        end
    end

    // R7: an accepted gate transfer always sat inside the three-level window
    assert_gate_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && src.is_gate) |-> (tgt.dpl <= eff && eff <= src.dpl));

    // R8: a stack switch only accompanies a strict privilege raise on a CALL
    assert_switch_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stack_sw |-> (new_pl < cur_pl) && is_call);

    // R4: a direct conforming target never changes the level
    assert_conforming_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src.is_code && !fault) |-> (new_pl == cur_pl) && !stack_sw);
endmodule

// File: rtl/far_xfer_gate_check.sv
// Top: decodes the referenced and target descriptors, applies the far
// transfer rules and registers the verdict one cycle after the request.
// Assumes descriptors are already fetched and stable with req_valid.
module far_xfer_gate_check
    import fxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_call,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [OFF_W-1:0]  ptr_off,
    input  logic [DESC_W-1:0] ref_desc,
    input  logic [DESC_W-1:0] tgt_desc,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [SEL_W-1:0]  rsp_sel,
    output logic [OFF_W-1:0]  rsp_off,
    output logic [PL_W-1:0]   rsp_cpl,
    output logic              rsp_stack_sw,
    output logic [CNT_W-1:0]  rsp_pcount
);
    localparam int N_DESC = 2;

    logic [N_DESC-1:0][DESC_W-1:0] raw;
    desc_info_t                    info [N_DESC];

    logic             d_fault;
    cause_t           d_cause;
    logic [SEL_W-1:0] d_sel;
    logic [OFF_W-1:0] d_off;
    logic [PL_W-1:0]  d_pl;
    logic             d_sw;
    logic [CNT_W-1:0] d_cnt;

    assign raw[0] = ref_desc;
    assign raw[1] = tgt_desc;

    // One identical decoder per descriptor input
    for (genvar g = 0; g < N_DESC; g++) begin : g_dec
        fxfer_desc_decode u_dec (
            .desc (raw[g]),
            .info (info[g])
        );
    end

    fxfer_rules u_rules (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_call  (req_is_call),
        .cur_pl   (cur_pl),
        .ptr_sel  (ptr_sel),
        .ptr_off  (ptr_off),
        .src      (info[0]),
        .tgt      (info[1]),
        .fault    (d_fault),
        .cause    (d_cause),
        .sel      (d_sel),
        .off      (d_off),
        .new_pl   (d_pl),
        .stack_sw (d_sw),
        .pcount   (d_cnt)
    );

    // Response register: clear on reset, capture on each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_cause    <= 2'd0;
            rsp_sel      <= '0;
            rsp_off      <= '0;
            rsp_cpl      <= '0;
            rsp_stack_sw <= 1'b0;
            rsp_pcount   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault    <= d_fault;
                rsp_cause    <= d_cause;
                rsp_sel      <= d_sel;
                rsp_off      <= d_off;
                rsp_cpl      <= d_pl;
                rsp_stack_sw <= d_sw;
                rsp_pcount   <= d_cnt;
            end
        end
    end

    // R2: a response follows each request by one cycle, and only then
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11: a refused transfer exposes no destination and no stack switch
    assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_sel == '0) && (rsp_off == '0)
                                     && !rsp_stack_sw && (rsp_pcount == '0));

    // R9: a stack switch is never granted for a JMP
    assert_jmp_no_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_stack_sw -> $past(req_is_call)));

    // R8: the granted selector carries the new level in its low bits
    assert_sel_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_sel[PL_W-1:0] == rsp_cpl));

    // R7: an allowed transfer never makes the level numerically larger
    assert_no_demote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_fault -> (rsp_cpl <= $past(cur_pl))));
endmodule

// File: tb/test_far_xfer_gate_check.sv
// Table-driven bench for far_xfer_gate_check, plus directed reset cases.
module test_far_xfer_gate_check;
    localparam logic [13:0] PTR_IDX   = 14'h048D;
    localparam logic [31:0] PTR_OFF   = 32'hCAFE_1234;
    localparam logic [13:0] GATE_IDX  = 14'h0296;
    localparam logic [15:0] GATE_HI   = 16'h89AB;
    localparam logic [15:0] GATE_LO   = 16'h4567;

    typedef struct packed {
        logic [3:0] req;
        logic       call;
        logic [1:0] cpl;
        logic [1:0] rpl;
        logic [1:0] kind;   // 0 code, 1 gate, 2 data, 3 other system
        logic [1:0] ddpl;
        logic       dconf;
        logic       d32;
        logic       tcode;
        logic [1:0] tdpl;
        logic       tconf;
        logic [4:0] cnt;
        logic       efault;
        logic [1:0] ecause;
        logic [1:0] ecpl;
        logic       esw;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 1'b0,2'd2,2'd1,2'd0,2'd2,1'b0,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b0,2'd0,2'd2,1'b0}, // R3 same level
        '{4'd3, 1'b1,2'd2,2'd2,2'd0,2'd1,1'b0,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b1,2'd2,2'd2,1'b0}, // R3 inner nc
        '{4'd3, 1'b1,2'd2,2'd2,2'd0,2'd3,1'b0,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b1,2'd2,2'd2,1'b0}, // R3 outer nc
        '{4'd4, 1'b0,2'd3,2'd3,2'd0,2'd0,1'b1,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b0,2'd0,2'd3,1'b0}, // R4 inner conf
        '{4'd4, 1'b1,2'd1,2'd0,2'd0,2'd3,1'b1,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b1,2'd2,2'd1,1'b0}, // R4 outer conf
        '{4'd5, 1'b1,2'd0,2'd0,2'd2,2'd0,1'b0,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b1,2'd1,2'd0,1'b0}, // R5 data
        '{4'd5, 1'b1,2'd0,2'd0,2'd3,2'd0,1'b0,1'b0,1'b1,2'd0,1'b0,5'd0, 1'b1,2'd1,2'd0,1'b0}, // R5 other sys
        '{4'd8, 1'b1,2'd3,2'd3,2'd1,2'd3,1'b0,1'b1,1'b1,2'd0,1'b0,5'd2, 1'b0,2'd0,2'd0,1'b1}, // R8 raise
        '{4'd9, 1'b0,2'd3,2'd3,2'd1,2'd3,1'b0,1'b1,1'b1,2'd0,1'b0,5'd2, 1'b1,2'd3,2'd3,1'b0}, // R9 jmp raise
        '{4'd6, 1'b1,2'd2,2'd1,2'd1,2'd3,1'b0,1'b0,1'b1,2'd2,1'b0,5'd7, 1'b0,2'd0,2'd2,1'b0}, // R6 16-bit gate
        '{4'd7, 1'b1,2'd2,2'd0,2'd1,2'd1,1'b0,1'b1,1'b1,2'd0,1'b0,5'd4, 1'b1,2'd2,2'd2,1'b0}, // R7 gate too low
        '{4'd8, 1'b1,2'd1,2'd3,2'd1,2'd3,1'b0,1'b1,1'b1,2'd0,1'b0,5'd31,1'b0,2'd0,2'd0,1'b1}, // R8 max count
        '{4'd7, 1'b1,2'd0,2'd2,2'd1,2'd3,1'b0,1'b1,1'b1,2'd1,1'b0,5'd3, 1'b1,2'd2,2'd0,1'b0}, // R7 outward tgt
        '{4'd7, 1'b1,2'd3,2'd0,2'd1,2'd3,1'b0,1'b1,1'b0,2'd0,1'b0,5'd3, 1'b1,2'd1,2'd3,1'b0}, // R7 tgt not code
        '{4'd10,1'b0,2'd3,2'd3,2'd1,2'd3,1'b0,1'b0,1'b1,2'd0,1'b1,5'd5, 1'b0,2'd0,2'd3,1'b0}, // R10 conf tgt
        '{4'd7, 1'b1,2'd3,2'd0,2'd1,2'd2,1'b0,1'b1,1'b1,2'd0,1'b0,5'd1, 1'b1,2'd2,2'd3,1'b0}, // R7 cpl > gate
        '{4'd7, 1'b1,2'd2,2'd3,2'd1,2'd3,1'b0,1'b1,1'b1,2'd3,1'b0,5'd1, 1'b1,2'd2,2'd2,1'b0}, // R7 window ok, outward
        '{4'd10,1'b0,2'd1,2'd1,2'd1,2'd3,1'b0,1'b1,1'b1,2'd1,1'b0,5'd9, 1'b0,2'd0,2'd1,1'b0}  // R10 same level
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_is_call;
    logic [1:0]  cur_pl;
    logic [15:0] ptr_sel;
    logic [31:0] ptr_off;
    logic [63:0] ref_desc;
    logic [63:0] tgt_desc;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [15:0] rsp_sel;
    logic [31:0] rsp_off;
    logic [1:0]  rsp_cpl;
    logic        rsp_stack_sw;
    logic [4:0]  rsp_pcount;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    far_xfer_gate_check i_far_xfer_gate_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_call  (req_is_call),
        .cur_pl       (cur_pl),
        .ptr_sel      (ptr_sel),
        .ptr_off      (ptr_off),
        .ref_desc     (ref_desc),
        .tgt_desc     (tgt_desc),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .rsp_cause    (rsp_cause),
        .rsp_sel      (rsp_sel),
        .rsp_off      (rsp_off),
        .rsp_cpl      (rsp_cpl),
        .rsp_stack_sw (rsp_stack_sw),
        .rsp_pcount   (rsp_pcount)
    );

    function automatic logic [63:0] mk_desc(input logic [1:0] kind, input logic [1:0] dpl,
                                            input logic conf, input logic d32, input logic [4:0] cnt);
        case (kind)
            2'd0:    mk_desc = {16'h00CF, 1'b1, dpl, 1'b1, 1'b1, conf, 1'b1, 1'b0, 8'h00, 32'h1234_FFFF};
            2'd1:    mk_desc = {GATE_HI, 1'b1, dpl, 1'b0, d32, 3'b100, 3'b000, cnt, GATE_IDX, 2'b11, GATE_LO};
            2'd2:    mk_desc = {16'h00CF, 1'b1, dpl, 1'b1, 4'b0011, 8'h00, 32'h1234_FFFF};
            default: mk_desc = {16'h0000, 1'b1, dpl, 1'b0, 4'b0101, 8'h00, 32'h1234_FFFF};
        endcase
    endfunction

    task automatic chk(input int req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid   = 1'b1;
        req_is_call = v.call;
        cur_pl      = v.cpl;
        ptr_sel     = {PTR_IDX, v.rpl};
        ptr_off     = PTR_OFF;
        ref_desc    = mk_desc(v.kind, v.ddpl, v.dconf, v.d32, v.cnt);
        tgt_desc    = mk_desc(v.tcode ? 2'd0 : 2'd2, v.tdpl, v.tconf, 1'b0, 5'd0);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_is_call = 1'b0; cur_pl = 2'd0;
        ptr_sel = '0; ptr_off = '0; ref_desc = '0; tgt_desc = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(1, "reset valid", rsp_valid, 0);
        chk(1, "reset fault", rsp_fault, 0);
        chk(1, "reset cause", rsp_cause, 0);
        chk(1, "reset cpl", rsp_cpl, 0);
        chk(1, "reset stack_sw", rsp_stack_sw, 0);
        chk(1, "reset pcount", rsp_pcount, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(2, "idle valid", rsp_valid, 0); // R2 no request, no response

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] esel;
            logic [31:0] eoff;
            int          rq;
            v = VECS[i];
            drive(v);
            @(negedge clk);
            if (v.efault) begin
                esel = '0; eoff = '0;
            end else if (v.kind == 2'd0) begin
                esel = {PTR_IDX, v.ecpl}; eoff = PTR_OFF;
            end else begin
                esel = {GATE_IDX, v.ecpl}; eoff = v.d32 ? {GATE_HI, GATE_LO} : {16'h0000, GATE_LO};
            end
            rq = v.efault ? 11 : int'(v.req); // R11 on fault rows
            chk(2, $sformatf("vec %0d valid", i), rsp_valid, 1);
            chk(int'(v.req), $sformatf("vec %0d fault", i), rsp_fault, v.efault);
            chk(int'(v.req), $sformatf("vec %0d cause", i), rsp_cause, v.ecause);
            chk(int'(v.req), $sformatf("vec %0d cpl", i), rsp_cpl, v.ecpl);
            chk(int'(v.req), $sformatf("vec %0d stack_sw", i), rsp_stack_sw, v.esw);
            chk(rq, $sformatf("vec %0d pcount", i), rsp_pcount, v.esw ? v.cnt : 5'd0);
            chk(rq, $sformatf("vec %0d sel", i), rsp_sel, esel);
            chk(rq, $sformatf("vec %0d off", i), rsp_off, eoff);
        end

        req_valid = 1'b0;
        @(negedge clk);
        chk(2, "valid drops after last request", rsp_valid, 0); // R2

        // R1: a raising CALL presented during reset yields nothing
        drive(VECS[7]);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, "request under reset valid", rsp_valid, 0);
        chk(1, "request under reset stack_sw", rsp_stack_sw, 0);
        chk(1, "request under reset pcount", rsp_pcount, 0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(2, "valid after reset release", rsp_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule